// File: doc/BRIEF.md
# SMP Miscellaneous Status and Interprocessor Interrupt Register

This block is one 64-bit control and status register shared by up to four processors. It holds the interprocessor interrupt flags and the interval-timer interrupt flags for each processor. It also holds two 4-bit arbitration-tracking fields and a small plain read/write field. The per-processor interrupt outputs are driven straight from the stored flags.

A single write applies several update rules to different fields at the same time. The flag fields are write-one-to-clear. A request field sets interprocessor flags without being stored itself. One arbitration field is write-one-to-set. The other arbitration field accepts a set only while it is empty. A control bit wipes both arbitration fields. A timer block outside this one raises the timer flags with single-cycle set pulses. A read returns the stored value with the requesting processor's index merged into the two lowest bits.

The register answers at one fixed offset only. The read path is combinational. A write or a timer pulse takes effect at the next rising clock edge.

Top module: `smp_misc_reg`

## Requirements
- R1: After reset every stored bit is zero and all `ipi_irq` and `timer_irq` outputs are low.
- R2: A read (`rd_en`=1) at `bus_addr` equal to `REG_OFFSET` (default 0x080) returns the stored value with `req_cpu` ORed into bits 1:0. A read at any other address returns zero. A write at any other address changes nothing.
- R3: A write of 1 to any bit in 4–11 clears that bit. Bits 4+i are the timer flags and bits 8+i are the interprocessor flags of CPU i. Bits written 0 are kept.
- R4: A write of 1 to bit 12+i sets interprocessor flag bit 8+i, even when the same write clears that flag. Bits 12–15 always read as zero.
- R5: Bits 20–23 are write-one-to-set: a 1 sets the bit and a 0 leaves it unchanged.
- R6: Bits 16–19 take the written ones only when all four bits are currently zero. Otherwise a write leaves them unchanged.
- R7: A write with bit 24 set clears bits 16–23 and sets none of them. Bit 24 reads as zero.
- R8: Every accepted write loads bits 40–43 with the written value.
- R9: `ipi_irq[i]` equals stored bit 8+i and `timer_irq[i]` equals stored bit 4+i. A write can raise or drop `ipi_irq`, but it can only drop `timer_irq`.
- R10: A pulse on `iti_set[i]` sets bit 4+i at the next edge. If a write clears the same bit in that cycle, the set wins.
- R11: Bit 28 is write-one-to-clear and no event sets it. All bits outside 4–11, 16–23, 28 and 40–43 read as zero, apart from the CPU index in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write value |
| rd_en | input | 1 | Read strobe |
| req_cpu | input | ID_W | Index of the requesting CPU |
| rd_data | output | 64 | Read value, combinational |
| iti_set | input | NUM_CPU | Per-CPU timer interrupt set pulses |
| ipi_irq | output | NUM_CPU | Per-CPU interprocessor interrupt |
| timer_irq | output | NUM_CPU | Per-CPU interval-timer interrupt |

## Verification
The bench builds the block with its defaults: four CPUs, a 12-bit offset and the register at 0x080. With these values every flag, request and arbitration bit maps onto a live output or a readable field. Random 12-bit addresses also hit neighbouring offsets, which exercises the miss path on reads and writes. Random 64-bit write data, sparse timer pulses and random requester indices produce the overlaps the update rules have to resolve: a clear together with a request, a clear together with a timer pulse, and the arbitration clear together with sets.

// File: rtl/smp_misc_pkg.sv
package smp_misc_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned FLAG_W    = 4;
  localparam int unsigned ITI_LSB   = 4;
  localparam int unsigned IPI_LSB   = 8;
  localparam int unsigned REQ_LSB   = 12;
  localparam int unsigned ARB_W     = 4;
  localparam int unsigned ARBZ_LSB  = 16;   // set only while empty
  localparam int unsigned ARBS_LSB  = 20;   // write-one-to-set
  localparam int unsigned ARB_CLR   = 24;
  localparam int unsigned STICKY    = 28;
  localparam int unsigned USER_LSB  = 40;
  localparam int unsigned USER_W    = 4;

  localparam logic [DATA_W-1:0] KEEP_MASK =
      (DATA_W'({FLAG_W{1'b1}}) << ITI_LSB) |
      (DATA_W'({FLAG_W{1'b1}}) << IPI_LSB) |
      (DATA_W'({ARB_W{1'b1}})  << ARBZ_LSB) |
      (DATA_W'({ARB_W{1'b1}})  << ARBS_LSB) |
      (DATA_W'(1'b1)           << STICKY) |
      (DATA_W'({USER_W{1'b1}}) << USER_LSB);
endpackage

// File: rtl/smp_misc_next.sv
module smp_misc_next
  import smp_misc_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic [DATA_W-1:0]  cur,
  input  logic               wr_hit,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_CPU-1:0] iti_set,
  output logic [DATA_W-1:0]  nxt,
  output logic               upd_en
);
  logic [FLAG_W-1:0] iti_ext;
  logic [DATA_W-1:0] n;
  logic              unused_wbits;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_iti
    if (i < NUM_CPU) begin : g_live
      assign iti_ext[i] = iti_set[i];
    end else begin : g_idle
      assign iti_ext[i] = 1'b0;
    end
  end

  assign unused_wbits = ^{wdata[DATA_W-1:USER_LSB+USER_W],
                          wdata[USER_LSB-1:STICKY+1],
                          wdata[STICKY-1:ARB_CLR+1],
                          wdata[ITI_LSB-1:0]};

  always_comb begin
    n = cur;
    if (wr_hit) begin
      n[ITI_LSB +: 2*FLAG_W] = n[ITI_LSB +: 2*FLAG_W] & ~wdata[ITI_LSB +: 2*FLAG_W];
      n[STICKY]              = n[STICKY] & ~wdata[STICKY];
      n[IPI_LSB +: FLAG_W]   = n[IPI_LSB +: FLAG_W] | wdata[REQ_LSB +: FLAG_W];
      if (wdata[ARB_CLR]) begin
        n[ARBZ_LSB +: 2*ARB_W] = '0;
      end else begin
        n[ARBS_LSB +: ARB_W] = n[ARBS_LSB +: ARB_W] | wdata[ARBS_LSB +: ARB_W];
        if (cur[ARBZ_LSB +: ARB_W] == '0) begin
          n[ARBZ_LSB +: ARB_W] = wdata[ARBZ_LSB +: ARB_W];
        end
      end
      n[USER_LSB +: USER_W] = wdata[USER_LSB +: USER_W];
    end
    n[ITI_LSB +: FLAG_W] = n[ITI_LSB +: FLAG_W] | iti_ext;
    nxt = n & KEEP_MASK;
  end

  assign upd_en = wr_hit | (|iti_set);
endmodule

// File: rtl/smp_misc_irq.sv
module smp_misc_irq
  import smp_misc_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic [2*FLAG_W-1:0] flags,
  output logic [NUM_CPU-1:0]  ipi_irq,
  output logic [NUM_CPU-1:0]  timer_irq
);
  logic unused_flags;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    assign timer_irq[i] = flags[i];
    assign ipi_irq[i]   = flags[FLAG_W + i];
  end

  assign unused_flags = ^flags;
endmodule

// File: rtl/smp_misc_rd.sv
module smp_misc_rd
  import smp_misc_pkg::*;
#(
  parameter int unsigned ID_W = 2
) (
  input  logic [DATA_W-1:0] q,
  input  logic              rd_hit,
  input  logic [ID_W-1:0]   req_cpu,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      rd_data = q | DATA_W'(req_cpu);
    end
  end
endmodule

// File: rtl/smp_misc_reg.sv
module smp_misc_reg
  import smp_misc_pkg::*;
#(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(12'h080),
  localparam int unsigned ID_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [ID_W-1:0]    req_cpu,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_CPU-1:0] iti_set,
  output logic [NUM_CPU-1:0] ipi_irq,
  output logic [NUM_CPU-1:0] timer_irq
);
  logic              addr_hit;
  logic              wr_hit;
  logic              rd_hit;
  logic              upd_en;
  logic [DATA_W-1:0] misc_q;
  logic [DATA_W-1:0] misc_d;

  assign addr_hit = (bus_addr == REG_OFFSET);
  assign wr_hit   = wr_en & addr_hit;
  assign rd_hit   = rd_en & addr_hit;

  smp_misc_next #(.NUM_CPU(NUM_CPU)) u_next (
    .cur     (misc_q),
    .wr_hit  (wr_hit),
    .wdata   (wr_data),
    .iti_set (iti_set),
    .nxt     (misc_d),
    .upd_en  (upd_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= '0;
    end else if (upd_en) begin
      misc_q <= misc_d;
    end
  end

  smp_misc_irq #(.NUM_CPU(NUM_CPU)) u_irq (
    .flags     (misc_q[ITI_LSB +: 2*FLAG_W]),
    .ipi_irq   (ipi_irq),
    .timer_irq (timer_irq)
  );

  smp_misc_rd #(.ID_W(ID_W)) u_rd (
    .q       (misc_q),
    .rd_hit  (rd_hit),
    .req_cpu (req_cpu),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/smp_misc_chk.sv
module smp_misc_chk
  import smp_misc_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(12'h080)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data,
  input logic [NUM_CPU-1:0] iti_set,
  input logic [NUM_CPU-1:0] ipi_irq,
  input logic [NUM_CPU-1:0] timer_irq,
  input logic [DATA_W-1:0]  misc_q
);
  logic wr_hit;
  assign wr_hit = wr_en && (bus_addr == REG_OFFSET);

  // R10
  iti_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|iti_set) |=> ((timer_irq & $past(iti_set)) == $past(iti_set)));

  // R3
  iti_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((timer_irq & $past(wr_data[ITI_LSB +: NUM_CPU] & ~iti_set)) == '0));

  // R4
  ipi_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((ipi_irq & $past(wr_data[REQ_LSB +: NUM_CPU])) == $past(wr_data[REQ_LSB +: NUM_CPU])));

  // R9
  ipi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ipi_irq));

  // R9
  timer_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|iti_set) |=> ((timer_irq & ~$past(timer_irq)) == '0));

  // R6
  arb_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wr_data[ARB_CLR] && misc_q[ARBZ_LSB +: ARB_W] != '0)
    |=> (misc_q[ARBZ_LSB +: ARB_W] == $past(misc_q[ARBZ_LSB +: ARB_W])));

  // R7
  arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data[ARB_CLR]) |=> (misc_q[ARBZ_LSB +: 2*ARB_W] == '0));

  // R8
  user_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (misc_q[USER_LSB +: USER_W] == $past(wr_data[USER_LSB +: USER_W])));
endmodule

bind smp_misc_reg smp_misc_chk #(
  .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
  .wr_data(wr_data), .iti_set(iti_set), .ipi_irq(ipi_irq),
  .timer_irq(timer_irq), .misc_q(misc_q)
);

// File: tb/tb_smp_misc_reg.sv
`timescale 1ns/1ps
module tb_smp_misc_reg;
  localparam logic [11:0] OFF = 12'h080;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        wr_en, rd_en;
  logic [63:0] wr_data;
  logic [1:0]  req_cpu;
  logic [63:0] rd_data;
  logic [3:0]  iti_set, ipi_irq, timer_irq;

  int          errors = 0;
  int          checks = 0;
  logic [63:0] model;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  smp_misc_reg dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .req_cpu(req_cpu), .rd_data(rd_data),
    .iti_set(iti_set), .ipi_irq(ipi_irq), .timer_irq(timer_irq)
  );

  // Expected register value after one edge, written from the requirements
  function automatic logic [63:0] expect_next(logic [63:0] cur, logic hit,
                                              logic [63:0] w, logic [3:0] pulse);
    logic [63:0] r = cur;
    if (hit) begin
      for (int b = 4; b < 12; b++) if (w[b]) r[b] = 1'b0;      // R3
      if (w[28]) r[28] = 1'b0;                                  // R11
      for (int c = 0; c < 4; c++) if (w[12+c]) r[8+c] = 1'b1;  // R4
      if (w[24]) r[23:16] = 8'h00;                              // R7
      else begin
        r[23:20] = r[23:20] | w[23:20];                         // R5
        if (cur[19:16] == 4'h0) r[19:16] = w[19:16];            // R6
      end
      r[43:40] = w[43:40];                                      // R8
    end
    for (int c = 0; c < 4; c++) if (pulse[c]) r[4+c] = 1'b1;   // R10
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Read the register and the interrupt outputs between edges
  task automatic probe(string tag);
    logic [1:0] id = 2'($urandom);
    rd_en = 1'b1; bus_addr = OFF; req_cpu = id;
    #2;
    check({tag, " R2 read"}, rd_data, model | {62'd0, id});
    check({tag, " R9 irq"}, {56'd0, ipi_irq, timer_irq}, {56'd0, model[11:8], model[7:4]});
    rd_en = 1'b0;
  endtask

  task automatic access(logic [11:0] a, logic we, logic [63:0] d, logic [3:0] p);
    @(negedge clk);
    bus_addr = a; wr_en = we; wr_data = d; iti_set = p;
    @(posedge clk);
    model = expect_next(model, we && (a == OFF), d, p);
    #1;
    wr_en = 1'b0; iti_set = 4'h0;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; bus_addr = '0;
    wr_data = '0; iti_set = '0; req_cpu = '0; model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2 probe("R1 reset");

    access(OFF, 1'b0, '0, 4'b0101);                 probe("R10 pulse");
    access(OFF, 1'b1, 64'h10, 4'b0001);             probe("R10 set wins");
    access(OFF, 1'b1, 64'hF0, 4'b0000);             probe("R3 timer clear");
    access(OFF, 1'b1, 64'hF000, 4'b0000);           probe("R4 request");
    access(OFF, 1'b1, 64'h2100, 4'b0000);           probe("R4 clear+request");
    access(OFF, 1'b1, 64'h00A0_0000, 4'b0000);      probe("R5 set");
    access(OFF, 1'b1, 64'h0050_0000, 4'b0000);      probe("R5 accumulate");
    access(OFF, 1'b1, 64'h0003_0000, 4'b0000);      probe("R6 empty set");
    access(OFF, 1'b1, 64'h000C_0000, 4'b0000);      probe("R6 held");
    access(OFF, 1'b1, 64'h01FF_0000, 4'b0000);      probe("R7 clear");
    access(OFF, 1'b1, 64'h0000_0A00_0000_0000, 4'b0); probe("R8 load A");
    access(OFF, 1'b1, 64'h0000_0500_0000_0000, 4'b0); probe("R8 load 5");
    access(OFF, 1'b1, 64'h3000, 4'b0);              probe("R2 setup");
    access(12'h0C0, 1'b1, '1, 4'b0);                probe("R2 miss write");
    @(negedge clk);
    rd_en = 1'b1; bus_addr = 12'h0C0; req_cpu = 2'd3;
    #2 check("R2 miss read", rd_data, 64'h0);
    rd_en = 1'b0;
    access(OFF, 1'b1, 64'hFFFF_FFFF_FEFF_FFFF, 4'b0); probe("R11 all ones");

    for (int k = 0; k < 300; k++) begin
      logic [11:0] a = ($urandom % 5 == 0) ? 12'($urandom) : OFF;
      logic [63:0] d = {$urandom, $urandom};
      logic [3:0]  p = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      if ($urandom % 4 != 0) d[24] = 1'b0;
      access(a, ($urandom % 4) != 0, d, p);
      probe("R3 R4 R5 R6 R10 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule